// File: doc/BRIEF.md
# Flash Read Timing Sequencer

This block runs single reads from a flash bank for a CPU bus clocked by HCLK. A CPU read request with an address is taken when the sequencer is idle. The address is held on the flash address lines and a flash bank clock pulse is launched. The sequencer then counts a programmable number of wait states and returns the word to the CPU with a one-cycle ready strobe. While a read is in flight a busy output holds further requests off, and requests seen during that time are dropped.

An 8-bit configuration word sets four things: the wait-state count, how long the flash clock stays high, whether that pulse starts on the rising or the falling edge of HCLK, and whether read data is captured in a register or forwarded straight from the flash outputs. The word is sampled when a request is taken and stays fixed for that read. Half-cycle timing on the flash clock comes from a mix of rising-edge and falling-edge flops on HCLK, so the block uses no second clock. The flash array sits outside the block. A typical 120 MHz setting uses zero in bits 4 and 3 and binary 01 in bits 6:5.

Top module: `flash_read_seq`

## Requirements
- R1: After reset, cpuBusy, cpuReady and flClk are all low and stay low until a request is taken.
- R2: cfgWord bits 3:0 give the wait-state count W. With bit 4 = 0 (registered path), a request taken at rising edge E drives cpuReady high for exactly one cycle, starting at edge E+W+1.
- R3: With cfgWord bit 4 = 1 (forwarding path), cpuReady is high for exactly one cycle, starting at edge E+W. During that cycle cpuRdata equals flRdata combinationally.
- R4: On the registered path, cpuRdata during the ready cycle equals the flash word for the requested address, captured at edge E+W+1.
- R5: cpuBusy is high from edge E through the ready cycle. A request asserted while cpuBusy is high is ignored: it causes no extra ready strobe and does not change flAddr.
- R6: cfgWord bits 7:6 set the flash clock high time in HCLK half-cycles: 00 is one half-cycle, 01 is two, 10 is three and 11 is four.
- R7: cfgWord bit 5 sets where the flash clock pulse starts. With 0 it rises at edge E. With 1 it rises at the HCLK falling edge that follows E.
- R8: flAddr shows the address taken at edge E and holds it for as long as cpuBusy is high.
- R9: A change to cfgWord after edge E has no effect on the wait count, data path, pulse width or pulse alignment of the read already in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | HCLK; both of its edges are used |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 8 | Timing configuration word, sampled when a request is taken |
| cpuReq | input | 1 | CPU read request, taken at a rising edge while idle |
| cpuAddr | input | AW | CPU read address |
| cpuBusy | output | 1 | High while a read is in flight; requests are not taken |
| cpuReady | output | 1 | One-cycle strobe marking valid cpuRdata |
| cpuRdata | output | DW | Read data returned to the CPU |
| flAddr | output | AW | Address driven to the flash bank |
| flClk | output | 1 | Flash bank clock pulse |
| flRdata | input | DW | Data from the flash bank |

## Verification
Two cases are the hardest to reach from the ports. The first is a request and a configuration change that arrive while a read is already in flight: they must change neither that read's timing nor its address. The bench produces this with "noisy" reads, which hold cpuReq high and put random addresses and configuration words on the inputs every cycle the read is busy. It lowers cpuReq in the exact cycle busy drops. The flash clock is sampled in the middle of both HCLK phases of every cycle after the request, so a pulse that is off by a half-cycle is seen. Directed reads cover every high-time and alignment combination, plus the zero-wait forwarding and fifteen-wait registered extremes. Random reads then mix the remaining settings.

// File: rtl/flash_rd_pkg.sv
`timescale 1ns/1ps
package flash_rd_pkg;

  localparam int CFG_W = 8;
  localparam int WS_W  = 4;

  // Field order follows the bit positions of the configuration word.
  typedef struct packed {
    logic [1:0]      hiSel;      // [7:6] high time in half-cycles minus one
    logic            lateEdge;   // [5]   pulse starts on falling edge
    logic            bypass;     // [4]   forward flash data combinationally
    logic [WS_W-1:0] waitStates; // [3:0] wait-state count
  } rdCfg_t;

  typedef struct packed {
    logic accept;    // request taken this edge
    logic capture;   // register flash data this edge
    logic fwdReady;  // ready with forwarded data this cycle
    logic regReady;  // ready with registered data this cycle
  } seqStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } seqState_e;

  function automatic rdCfg_t decodeCfg(input logic [CFG_W-1:0] word);
    return rdCfg_t'(word);
  endfunction

endpackage

// File: rtl/flash_rd_ctrl.sv
`timescale 1ns/1ps
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int WAIT_W = WS_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgBypass,
  output seqStrb_t          strb,
  output logic              cpuBusy
);

  seqState_e         state;
  logic [WAIT_W-1:0] waitCnt;
  logic              bypassQ;
  logic              acceptNow;
  logic              lastWait;

  always_comb begin
    acceptNow     = (state == ST_IDLE) && cpuReq;
    lastWait      = (state == ST_WAIT) && (waitCnt == '0);
    strb.accept   = acceptNow;
    strb.capture  = lastWait && !bypassQ;
    strb.fwdReady = lastWait && bypassQ;
    strb.regReady = (state == ST_DONE);
    cpuBusy       = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      bypassQ <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acceptNow) begin
            state   <= ST_WAIT;
            waitCnt <= cfgWait;
            bypassQ <= cfgBypass;
          end
        end
        ST_WAIT: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - 1'b1;
          end else begin
            state <= bypassQ ? ST_IDLE : ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_IDLE)); // R2

  AST_WAIT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && waitCnt != '0) |=> (state == ST_WAIT && waitCnt == $past(waitCnt) - 1'b1)); // R2

  AST_NO_TAKE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strb.accept); // R5

endmodule

// File: rtl/flash_rd_dp.sv
`timescale 1ns/1ps
module flash_rd_dp
  import flash_rd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
)(
  input  logic          clk,
  input  logic          rstN,
  input  seqStrb_t      strb,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] flRdata,
  output logic [AW-1:0] flAddr,
  output logic [DW-1:0] cpuRdata,
  output logic          cpuReady
);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (strb.accept)  addrQ <= cpuAddr;
      if (strb.capture) dataQ <= flRdata;
    end
  end

  always_comb begin
    flAddr   = addrQ;
    cpuReady = strb.fwdReady | strb.regReady;
    cpuRdata = strb.fwdReady ? flRdata : dataQ;
  end

  AST_REG_DATA_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (strb.regReady && cpuRdata == $past(flRdata))); // R4

endmodule

// File: rtl/flash_clk_gen.sv
`timescale 1ns/1ps
module flash_clk_gen (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic [1:0] cfgHiSel,
  input  logic       cfgLate,
  output logic       flClk
);

  localparam int CYC_W   = 2;
  localparam logic [CYC_W-1:0] CYC_MAX = '1;

  logic [CYC_W-1:0] pulseCyc;
  logic [1:0]       hiSelQ;
  logic             lateQ;
  logic             riseHi;
  logic             fallPend;
  logic             fallHi;

  function automatic logic inWin(input logic [CYC_W:0] half, input logic late,
                                 input logic [1:0] hi);
    logic [3:0] h, s, e;
    h = {1'b0, half};
    s = {3'b000, late};
    e = s + {2'b00, hi} + 4'd1;
    return (h >= s) && (h < e);
  endfunction

  // Rising-edge domain: decides both halves of the coming cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCyc <= CYC_MAX;
      hiSelQ   <= '0;
      lateQ    <= 1'b0;
      riseHi   <= 1'b0;
      fallPend <= 1'b0;
    end else if (accept) begin
      hiSelQ   <= cfgHiSel;
      lateQ    <= cfgLate;
      riseHi   <= inWin({1'b0, 2'd0}, cfgLate, cfgHiSel);
      fallPend <= inWin({1'b0, 2'd0} | 3'd1, cfgLate, cfgHiSel);
      pulseCyc <= 2'd1;
    end else begin
      riseHi   <= inWin({pulseCyc, 1'b0}, lateQ, hiSelQ);
      fallPend <= inWin({pulseCyc, 1'b1}, lateQ, hiSelQ);
      if (pulseCyc != CYC_MAX) pulseCyc <= pulseCyc + 1'b1;
    end
  end

  // Falling-edge domain: presents the second half of the cycle.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallHi <= 1'b0;
    else       fallHi <= fallPend;
  end

  assign flClk = clk ? riseHi : fallHi;

  AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pulseCyc == CYC_MAX && !accept) |=> (!riseHi && !fallPend)); // R6

  AST_LATE_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cfgLate) |=> (!riseHi && fallPend)); // R7

endmodule

// File: rtl/flash_read_seq.sv
`timescale 1ns/1ps
module flash_read_seq
  import flash_rd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             cpuReq,
  input  logic [AW-1:0]    cpuAddr,
  output logic             cpuBusy,
  output logic             cpuReady,
  output logic [DW-1:0]    cpuRdata,
  output logic [AW-1:0]    flAddr,
  output logic             flClk,
  input  logic [DW-1:0]    flRdata
);

  rdCfg_t   cfgLive;
  seqStrb_t strb;

  assign cfgLive = decodeCfg(cfgWord);

  flash_rd_ctrl #(.WAIT_W(WS_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .cfgWait   (cfgLive.waitStates),
    .cfgBypass (cfgLive.bypass),
    .strb      (strb),
    .cpuBusy   (cpuBusy)
  );

  flash_rd_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuAddr  (cpuAddr),
    .flRdata  (flRdata),
    .flAddr   (flAddr),
    .cpuRdata (cpuRdata),
    .cpuReady (cpuReady)
  );

  flash_clk_gen u_clk (
    .clk      (clk),
    .rstN     (rstN),
    .accept   (strb.accept),
    .cfgHiSel (cfgLive.hiSel),
    .cfgLate  (cfgLive.lateEdge),
    .flClk    (flClk)
  );

  AST_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuBusy); // R5

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cpuBusy && $past(cpuBusy)) |-> $stable(flAddr)); // R8

endmodule

// File: tb/sim_flash_read_seq.sv
`timescale 1ns/1ps
module sim_flash_read_seq;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    cfgWord = '0;
  logic          cpuReq = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic          cpuBusy, cpuReady, flClk;
  logic [DW-1:0] cpuRdata, flRdata;
  logic [AW-1:0] flAddr;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  flash_read_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .cpuReq(cpuReq), .cpuAddr(cpuAddr),
    .cpuBusy(cpuBusy), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .flAddr(flAddr), .flClk(flClk), .flRdata(flRdata)
  );

  // Behavioural flash array: one word per address.
  function automatic logic [DW-1:0] flashWord(input logic [AW-1:0] a);
    return {a, ~a} ^ 32'h5A3C_96E1;
  endfunction
  assign flRdata = flashWord(flAddr);

  function automatic logic expHi(input int half, input logic [7:0] c);
    int s, len;
    s   = int'(c[5]);
    len = int'(c[7:6]) + 1;
    return (half >= s) && (half < s + len);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [AW-1:0] addr, input logic [7:0] cfg, input bit noisy);
    int w, lastBusy, nInt;
    bit byp, expRdy;
    string sfx;
    w        = int'(cfg[3:0]);
    byp      = cfg[4];
    lastBusy = byp ? w : w + 1;
    nInt     = (lastBusy + 2 > 4) ? lastBusy + 2 : 4;
    sfx      = noisy ? " (R9 cfg churn)" : "";
    @(posedge clk); #1;
    cpuReq = 1'b1; cpuAddr = addr; cfgWord = cfg;
    @(posedge clk);                     // accept edge E
    for (int j = 0; j < nInt; j++) begin
      if (j > 0) @(posedge clk);
      #1;
      cpuReq = noisy && (j <= lastBusy);
      if (noisy) begin
        cpuAddr = AW'($urandom);
        cfgWord = 8'($urandom);
      end
      #0.25;                            // HCLK high phase, half 2j
      chk({"R6 R7 flash clock high phase", sfx}, DW'(flClk), DW'(expHi(2 * j, cfg)));
      expRdy = byp ? (j == w) : (j == w + 1);
      chk(byp ? {"R3 forward ready timing", sfx} : {"R2 registered ready timing", sfx},
          DW'(cpuReady), DW'(expRdy));
      chk({"R5 busy window", sfx}, DW'(cpuBusy), DW'(j <= lastBusy));
      if (expRdy)
        chk(byp ? "R3 forwarded data" : "R4 registered data", cpuRdata, flashWord(addr));
      if (j <= lastBusy)
        chk(noisy ? "R5 R8 address held under extra requests" : "R8 address held",
            DW'(flAddr), DW'(addr));
      #2.5;                             // HCLK low phase, half 2j+1
      chk({"R6 R7 flash clock low phase", sfx}, DW'(flClk), DW'(expHi(2 * j + 1, cfg)));
    end
    cpuReq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state, both phases
    repeat (3) @(posedge clk);
    #1.25;
    chk("R1 busy in reset", DW'(cpuBusy), '0);
    chk("R1 ready in reset", DW'(cpuReady), '0);
    chk("R1 flash clock high phase in reset", DW'(flClk), '0);
    #2.5;
    chk("R1 flash clock low phase in reset", DW'(flClk), '0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1.25;
    chk("R1 busy after reset", DW'(cpuBusy), '0);
    chk("R1 flash clock after reset", DW'(flClk), '0);

    // Directed corners
    doRead(16'h0120, 8'b0010_0010, 1'b0);   // 120 MHz style setting
    doRead(16'h0000, 8'h10, 1'b0);          // zero wait, forwarding
    doRead(16'hFFFF, 8'h0F, 1'b0);          // fifteen waits, registered
    doRead(16'h1234, 8'h00, 1'b0);          // zero wait, registered
    doRead(16'hBEEF, 8'h1F, 1'b0);          // fifteen waits, forwarding
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 2; b++)
          doRead(AW'(h * 77 + l * 5 + b), {2'(h), 1'(l), 1'(b), 4'd1}, 1'b0);
    doRead(16'hA5A5, 8'b1110_0011, 1'b1);   // R9 and R5 under churn
    doRead(16'h5A5A, 8'b0101_0000, 1'b1);

    // Constrained random mix
    for (int k = 0; k < 60; k++)
      doRead(AW'($urandom), 8'($urandom), 1'($urandom));

    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule